// File: doc/BRIEF.md
# National-Decimal to Packed-Decimal Converter

This block turns a 128-bit operand that holds a signed number written as eight 16-bit character codes into a signed packed-decimal value. Halfword 0, the least significant, holds the sign character. Halfwords 1 to 7 hold one decimal digit character each. The result puts one 4-bit digit in each nibble, with a sign code in nibble 0. The block also returns a 4-bit condition code. That code reports whether the value is zero, positive or negative, or whether the operand held a bad character.

A caller presents the operand, a preferred-sign select bit and a one-cycle valid strobe. One clock later the packed result and the condition code appear on registered outputs, together with a one-cycle valid pulse. The outputs keep their values until the next strobe. The reset, `rst_n`, clears the outputs asynchronously. Its release is expected to be synchronous to `clk`.

Top module: `natdec_pack_conv`

## Requirements
- R1: Halfword 0 (bits 15:0) of the operand is the sign character. Code 0x2B means plus and code 0x2D means minus.
- R2: Halfword i (bits 16i+15:16i, i = 1..7) is a valid digit only when its full 16-bit value lies in 0x30..0x39. Its low four bits are written to result nibble i (bits 4i+3:4i).
- R3: Digits are scanned upward from halfword 1. At the first out-of-range digit, scanning stops: that nibble and every higher digit nibble are 0, and the lower nibbles keep their digits.
- R4: For a plus sign, result nibble 0 is 0xC when the preferred-sign bit is 0 and 0xF when it is 1.
- R5: For a minus sign, and for any sign character other than 0x2B or 0x2D, result nibble 0 is 0xD.
- R6: The condition code bits are {LT, GT, EQ, SO}, from bit 3 down to bit 0. When the operand is valid and all digit nibbles (bits 31:4) are zero, the code is 4'b0010.
- R7: When the operand is valid and some digit nibble is non-zero, the code is 4'b0100 for a plus sign and 4'b1000 for a minus sign.
- R8: When the sign character is unrecognised or any digit is out of range, the code is 4'b0001. The packed result is still delivered as R2 to R5 build it.
- R9: Result bits 127:32 are always zero.
- R10: The result and the code are registered. They change only on the clock after in_valid is high, and `out_valid` is high for exactly that one cycle. Otherwise the outputs hold their values.
- R11: While `rst_n` is low, `out_valid`, `out_result` and `out_cc` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserted asynchronously, released synchronously |
| in_valid | input | 1 | Operand strobe |
| in_opnd | input | 128 | Eight 16-bit character codes; sign character in the lowest halfword |
| in_pref_sign | input | 1 | Selects the plus code: 0 gives 0xC, 1 gives 0xF |
| out_valid | output | 1 | One-cycle pulse, one clock after in_valid |
| out_result | output | 128 | Packed signed decimal result |
| out_cc | output | 4 | Condition code {LT, GT, EQ, SO} |

## Verification
The bench targets a bad digit at the lowest index, in the middle and at the top halfword. A design that skipped the bad digit and kept scanning would leave non-zero nibbles above the stop point. Digit codes just outside the range (0x2F, 0x3A), and codes whose upper byte is set (0x0135), catch a check that only looks at the low byte: such a design would accept them as digits and report GT or LT where SO is due. An unrecognised sign with all-zero digits, and a minus zero, catch a design that lets EQ beat SO or that tests the sign nibble instead of the digit nibbles. A single hold cycle between strobes shows whether stale results leak out or valid pulses stretch.

// File: rtl/natdec_pkg.sv
package natdec_pkg;
  localparam int CHAR_W     = 16;
  localparam int NIB_W      = 4;
  localparam int NUM_DIGITS = 7;
  localparam int DATA_W     = CHAR_W * (NUM_DIGITS + 1);
  localparam int CC_W       = 4;

  localparam logic [CHAR_W-1:0] CHR_PLUS  = 16'h002B;
  localparam logic [CHAR_W-1:0] CHR_MINUS = 16'h002D;
  localparam logic [CHAR_W-1:0] CHR_ZERO  = 16'h0030;
  localparam logic [CHAR_W-1:0] CHR_NINE  = 16'h0039;

  localparam logic [NIB_W-1:0] SGN_PLUS_A = 4'hC;
  localparam logic [NIB_W-1:0] SGN_PLUS_B = 4'hF;
  localparam logic [NIB_W-1:0] SGN_MINUS  = 4'hD;

  typedef enum logic [CC_W-1:0] {
    CC_NONE = 4'b0000,
    CC_SO   = 4'b0001,
    CC_EQ   = 4'b0010,
    CC_GT   = 4'b0100,
    CC_LT   = 4'b1000
  } cc_t;
endpackage

// File: rtl/natdec_digit_scan.sv
module natdec_digit_scan
  import natdec_pkg::*;
#(
  parameter int N_DIG  = NUM_DIGITS,
  parameter int CHR_W  = CHAR_W,
  localparam int DIG_W = N_DIG * NIB_W
) (
  input  logic [N_DIG*CHR_W-1:0] chars_i,
  output logic [DIG_W-1:0]       digits_o,
  output logic                   digit_bad_o
);
  // alive[k] is high while every character below digit k was in range
  logic [N_DIG:0] alive;
  assign alive[0] = 1'b1;

  for (genvar g = 0; g < N_DIG; g++) begin : g_dig
    logic [CHR_W-1:0] chr;
    logic             in_rng;
    assign chr    = chars_i[g*CHR_W +: CHR_W];
    assign in_rng = (chr >= CHR_ZERO) && (chr <= CHR_NINE);
    assign alive[g+1] = alive[g] & in_rng;
    assign digits_o[g*NIB_W +: NIB_W] = alive[g+1] ? chr[NIB_W-1:0] : '0;
  end

  assign digit_bad_o = ~alive[N_DIG];
endmodule

// File: rtl/natdec_sign_map.sv
module natdec_sign_map
  import natdec_pkg::*;
(
  input  logic [CHAR_W-1:0] sign_chr_i,
  input  logic              pref_i,
  output logic [NIB_W-1:0]  sign_nib_o,
  output logic              is_plus_o,
  output logic              sign_bad_o
);
  logic is_minus;

  always_comb begin
    is_plus_o  = (sign_chr_i == CHR_PLUS);
    is_minus   = (sign_chr_i == CHR_MINUS);
    sign_bad_o = ~(is_plus_o | is_minus);
    if (is_plus_o) begin
      sign_nib_o = pref_i ? SGN_PLUS_B : SGN_PLUS_A;
    end else begin
      sign_nib_o = SGN_MINUS;
    end
  end
endmodule

// File: rtl/natdec_cc_gen.sv
module natdec_cc_gen
  import natdec_pkg::*;
#(
  parameter int DIG_W = NUM_DIGITS * NIB_W
) (
  input  logic [DIG_W-1:0] digits_i,
  input  logic             is_plus_i,
  input  logic             invalid_i,
  output logic [CC_W-1:0]  cc_o
);
  always_comb begin
    if (invalid_i) begin
      cc_o = CC_SO;
    end else if (digits_i == '0) begin
      cc_o = CC_EQ;
    end else if (is_plus_i) begin
      cc_o = CC_GT;
    end else begin
      cc_o = CC_LT;
    end
  end
endmodule

// File: rtl/natdec_pack_conv.sv
module natdec_pack_conv
  import natdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_opnd,
  input  logic              in_pref_sign,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic [CC_W-1:0]   out_cc
);
  localparam int DIG_W  = NUM_DIGITS * NIB_W;
  localparam int PACK_W = DIG_W + NIB_W;
  localparam int PAD_W  = DATA_W - PACK_W;

  logic [DIG_W-1:0]  digits;
  logic              digit_bad;
  logic [NIB_W-1:0]  sign_nib;
  logic              is_plus;
  logic              sign_bad;
  logic [CC_W-1:0]   cc_comb;
  logic [DATA_W-1:0] result_nxt;
  logic [CC_W-1:0]   cc_nxt;
  logic              valid_nxt;

  natdec_digit_scan #(.N_DIG(NUM_DIGITS), .CHR_W(CHAR_W)) u_scan (
    .chars_i     (in_opnd[DATA_W-1:CHAR_W]),
    .digits_o    (digits),
    .digit_bad_o (digit_bad)
  );

  natdec_sign_map u_sign (
    .sign_chr_i (in_opnd[CHAR_W-1:0]),
    .pref_i     (in_pref_sign),
    .sign_nib_o (sign_nib),
    .is_plus_o  (is_plus),
    .sign_bad_o (sign_bad)
  );

  natdec_cc_gen #(.DIG_W(DIG_W)) u_cc (
    .digits_i  (digits),
    .is_plus_i (is_plus),
    .invalid_i (digit_bad | sign_bad),
    .cc_o      (cc_comb)
  );

  // next-state: load on strobe, hold otherwise
  always_comb begin
    valid_nxt  = in_valid;
    result_nxt = out_result;
    cc_nxt     = out_cc;
    if (in_valid) begin
      result_nxt = {{PAD_W{1'b0}}, digits, sign_nib};
      cc_nxt     = cc_comb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_cc     <= '0;
    end else begin
      out_valid  <= valid_nxt;
      out_result <= result_nxt;
      out_cc     <= cc_nxt;
    end
  end

  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_cc)));
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result[DATA_W-1:PACK_W] == '0));
  assert_cc_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_cc) == 1));
  assert_sign_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result[NIB_W-1:0] == SGN_PLUS_A ||
                   out_result[NIB_W-1:0] == SGN_PLUS_B ||
                   out_result[NIB_W-1:0] == SGN_MINUS));
  assert_so_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_opnd[CHAR_W-1:0] != CHR_PLUS && in_opnd[CHAR_W-1:0] != CHR_MINUS)
      |=> (out_cc == CC_SO));
endmodule

// File: tb/natdec_pack_conv_tb.sv
module natdec_pack_conv_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_opnd = '0;
  logic         in_pref_sign = 1'b0;
  logic         out_valid;
  logic [127:0] out_result;
  logic [3:0]   out_cc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit model_on = 1'b0;

  logic         exp_valid = 1'b0;
  logic [127:0] exp_res = '0;
  logic [3:0]   exp_cc = '0;
  bit           exp_plus = 1'b0;
  bit           exp_dbad = 1'b0;
  bit           exp_bad = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  natdec_pack_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opnd(in_opnd),
    .in_pref_sign(in_pref_sign), .out_valid(out_valid),
    .out_result(out_result), .out_cc(out_cc)
  );

  // behavioural reference of the conversion
  task automatic ref_conv(input logic [127:0] op, input logic pref,
                          output logic [127:0] r, output logic [3:0] cc,
                          output bit plus, output bit dbad, output bit bad);
    int stop;
    int h;
    int s;
    r = '0; stop = 0; dbad = 0;
    s = int'(op[15:0]);
    for (int i = 1; i < 8; i++) begin
      h = int'(op[16*i +: 16]);
      if (stop == 0) begin
        if (h >= 48 && h <= 57) r[4*i +: 4] = 4'(h % 16);
        else begin stop = 1; dbad = 1; end
      end
    end
    plus = (s == 43);
    r[3:0] = plus ? (pref ? 4'hF : 4'hC) : 4'hD;
    bad = dbad || (s != 43 && s != 45);
    if (r[31:4] == '0) cc = 4'b0010;
    else if (plus) cc = 4'b0100;
    else cc = 4'b1000;
    if (bad) cc = 4'b0001;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 1'b0; exp_res <= '0; exp_cc <= '0;
    end else if (model_on) begin
      exp_valid <= in_valid;
      if (in_valid) begin
        logic [127:0] r; logic [3:0] c; bit p; bit d; bit b;
        ref_conv(in_opnd, in_pref_sign, r, c, p, d, b);
        exp_res <= r; exp_cc <= c; exp_plus <= p; exp_dbad <= d; exp_bad <= b;
      end
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && rst_n && !done) begin
      chk("R10 out_valid", 128'(out_valid), 128'(exp_valid));
      chk("R9 upper bits", 128'(out_result[127:32]), 128'(exp_res[127:32]));
      chk(exp_plus ? "R1 R4 sign nibble" : "R1 R5 sign nibble",
          128'(out_result[3:0]), 128'(exp_res[3:0]));
      chk(exp_dbad ? "R3 digit nibbles" : "R2 digit nibbles",
          128'(out_result[31:4]), 128'(exp_res[31:4]));
      chk(exp_bad ? "R8 cc" : (exp_res[31:4] == '0 ? "R6 cc" : "R7 cc"),
          128'(out_cc), 128'(exp_cc));
    end
  end

  function automatic logic [127:0] mk(input logic [15:0] sg, input int d7, input int d6,
      input int d5, input int d4, input int d3, input int d2, input int d1);
    return {16'(d7), 16'(d6), 16'(d5), 16'(d4), 16'(d3), 16'(d2), 16'(d1), sg};
  endfunction

  task automatic send(input logic [127:0] op, input logic pref);
    @(posedge clk); #1;
    in_valid = 1'b1; in_opnd = op; in_pref_sign = pref;
    @(posedge clk); #1;
    in_valid = 1'b0; in_opnd = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; in_opnd = {8{16'h0031}}; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: outputs cleared during reset
    n_checks++;
    if (out_valid !== 1'b0 || out_result !== '0 || out_cc !== 4'b0) begin
      n_fail++;
      $display("FAIL R11 reset: actual %b/%h/%b expected 0/0/0", out_valid, out_result, out_cc);
    end
    rst_n = 1'b1;
    model_on = 1'b1;
    idle(2);
    send(mk(16'h002B, 'h31, 'h32, 'h33, 'h34, 'h35, 'h36, 'h37), 1'b0); // R4 plus, pref 0
    send(mk(16'h002B, 'h39, 'h38, 'h37, 'h36, 'h35, 'h34, 'h33), 1'b1); // R4 plus, pref 1
    send(mk(16'h002D, 'h30, 'h30, 'h30, 'h30, 'h30, 'h30, 'h35), 1'b1); // R5 minus, R7 LT
    send(mk(16'h002B, 'h30, 'h30, 'h30, 'h30, 'h30, 'h30, 'h30), 1'b0); // R6 plus zero
    send(mk(16'h002D, 'h30, 'h30, 'h30, 'h30, 'h30, 'h30, 'h30), 1'b0); // R6 minus zero
    send(mk(16'h0020, 'h31, 'h32, 'h33, 'h34, 'h35, 'h36, 'h37), 1'b1); // R8 bad sign
    send(mk(16'h012B, 'h30, 'h30, 'h30, 'h30, 'h30, 'h30, 'h30), 1'b0); // R1 R8 bad sign, zero
    send(mk(16'h002B, 'h31, 'h32, 'h33, 'h34, 'h35, 'h36, 'h2F), 1'b0); // R3 bad at index 1
    send(mk(16'h002D, 'h31, 'h32, 'h33, 'h3A, 'h35, 'h36, 'h37), 1'b0); // R3 bad at index 4
    send(mk(16'h002B, 'h0135, 'h32, 'h33, 'h34, 'h35, 'h36, 'h37), 1'b1); // R2 R3 bad at 7
    idle(1);
    // back-to-back strobes, R10
    @(posedge clk); #1;
    in_valid = 1'b1; in_opnd = mk(16'h002D, 'h34, 'h33, 'h32, 'h31, 'h30, 'h39, 'h38);
    @(posedge clk); #1;
    in_opnd = mk(16'h002B, 'h30, 'h30, 'h30, 'h30, 'h30, 'h30, 'h31);
    @(posedge clk); #1;
    in_valid = 1'b0;
    idle(2);
    for (int k = 0; k < 300; k++) begin
      logic [127:0] op;
      for (int j = 1; j < 8; j++) begin
        int u = $urandom_range(0, 30);
        op[16*j +: 16] = (u == 0) ? 16'($urandom) : 16'(16'h30 + $urandom_range(0, 9));
      end
      case ($urandom_range(0, 4))
        0: op[15:0] = 16'($urandom);
        1, 2: op[15:0] = 16'h002B;
        default: op[15:0] = 16'h002D;
      endcase
      if ($urandom_range(0, 3) == 0) op[127:16] = {7{16'h0030}};
      @(posedge clk); #1;
      in_valid = 1'($urandom_range(0, 3) != 0);
      in_opnd = op;
      in_pref_sign = 1'($urandom);
    end
    @(posedge clk); #1; in_valid = 1'b0;
    idle(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule